// File: doc/BRIEF.md
# Seconds Counter with Match Alarms

This core keeps time in whole seconds. A one-cycle pulse on `sec_tick_i` advances a 32-bit up-counter and, in lockstep, steps a companion down-counter that software keeps as the bitwise inverse of the up-counter. Two compare channels watch the up-counter. When a channel is armed and its value matches, the core latches a status flag. That flag can raise the interrupt line, and it can also drive a wake-up pin that leaves the chip.

Software reaches every register through a single-cycle synchronous word bus. The bus takes a select, a write strobe, a word index, write data and returns registered read data. The two counters are loaded while a freeze bit in the control word is set, so a tick can never land between the two loads. A general-purpose key word survives the internal soft reset, which lets boot code tell whether first-time setup has already been done. Firmware conventionally writes 0xB5C13F27 to it for that purpose. A match register parked at all-ones stops an alarm from re-firing in practice.

Top module: `sec_alarm_core`

## Requirements
- R1: After `rst_n` is released, the register reads are: up-counter 0x00000000, down-counter 0xFFFFFFFF, both match words 0xFFFFFFFF, control 0, status 0, key 0. Both `irq_o` and `wake_o` are low.
- R2: The word indices are: up-counter 0, down-counter 1, match A 2, match B 3, control 4, status 5, key 6. A read (select high, write low) returns the addressed word on `bus_rdata_o` one cycle later. Each tick pulse adds one to the up-counter and subtracts one from the down-counter at the same edge.
- R3: While control bit 6 (freeze) is set, ticks change neither counter.
- R4: A bus write to index 0 or 1 loads that counter at the write edge, including while frozen. Once the down-counter is the inverse of the up-counter, it stays the inverse across ticks.
- R5: Status bit 0 (or bit 1) is set at the edge after the up-counter equals match A (or match B) while control bit 0 (or bit 1) is set. A match word of 0xFFFFFFFF never matches a running count below it.
- R6: A write to the status word clears each bit written as 1 and keeps each bit written as 0. If a bit is set and cleared in the same cycle, the set wins.
- R7: `irq_o` is high when any of the following holds: status bit 0 is set with control bit 0 set; status bit 1 is set with control bit 1 set; status bit 2 is set with control bit 2 or bit 3 set. Clearing an enable drops `irq_o` but keeps the status bit.
- R8: `wake_o` is high when any of the following holds: control bit 7 (force) is set; status bit 0 is set with control bit 2 set; status bit 1 is set with control bit 3 set.
- R9: Status bit 2 is set at the edge after `wake_o` goes from low to high.
- R10: While control bit 4 (soft reset) is set, the counters are held at 0 and 0xFFFFFFFF and the status word is held at 0. Match words, key and control keep their values.
- R11: The key word holds any 32-bit value written to it. Control bit 5 always reads 0. Unmapped indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick_i | input | 1 | One-cycle pulse per second |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_idx_i | input | 6 | Word index of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Level interrupt request |
| wake_o | output | 1 | Wake-up pin |

## Verification
Timing of results:
- A write, and a tick, take effect at the edge that samples them.
- A match flag appears one edge after the counter reaches its value.
- The wake-pin flag needs one more edge after that.
- Read data trails its request by one edge.
- `irq_o` and `wake_o` follow the status and control registers with no added delay.

A driver task queues each expected read word as it issues the read. A monitor pops the queue and compares on the falling edge after the capture edge. Pin checks sit on falling edges placed by explicit idle cycles. This exposes the cases where a read issued too early would still see the old status.

// File: rtl/sac_pkg.sv
package sac_pkg;
  localparam int IDX_W   = 6;
  localparam int CTRL_W  = 8;
  localparam int ST_W    = 3;
  localparam int NCH     = 2;

  localparam int W_UP    = 0;
  localparam int W_DN    = 1;
  localparam int W_MA    = 2;
  localparam int W_MB    = 3;
  localparam int W_CTRL  = 4;
  localparam int W_STAT  = 5;
  localparam int W_KEY   = 6;

  localparam int C_MEN0  = 0;
  localparam int C_MEN1  = 1;
  localparam int C_PEN0  = 2;
  localparam int C_PEN1  = 3;
  localparam int C_SRST  = 4;
  localparam int C_FRZ   = 6;
  localparam int C_FORCE = 7;
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 8'hDF;

  localparam int S_WAKE  = 2;

  function automatic logic [ST_W-1:0] stat_next(input logic [ST_W-1:0] cur,
                                                 input logic [ST_W-1:0] set,
                                                 input logic [ST_W-1:0] clr,
                                                 input logic wipe);
    if (wipe) return '0;
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/sac_counter.sv
module sac_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          hold_i,
  input  logic          clear_i,
  input  logic          ld_up_i,
  input  logic          ld_dn_i,
  input  logic [DW-1:0] ld_val_i,
  output logic [DW-1:0] up_o,
  output logic [DW-1:0] dn_o,
  output logic          step_o
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  function automatic logic [DW-1:0] fwd(input logic [DW-1:0] v);
    return v + ONE;
  endfunction

  function automatic logic [DW-1:0] bwd(input logic [DW-1:0] v);
    return v - ONE;
  endfunction

  assign step_o = tick_i && !hold_i && !clear_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_o <= '0;
      dn_o <= '1;
    end else if (clear_i) begin
      up_o <= '0;
      dn_o <= '1;
    end else begin
      if (ld_up_i)     up_o <= ld_val_i;
      else if (step_o) up_o <= fwd(up_o);
      if (ld_dn_i)     dn_o <= ld_val_i;
      else if (step_o) dn_o <= bwd(dn_o);
    end
  end
endmodule

// File: rtl/sac_compare.sv
module sac_compare #(
  parameter int DW  = 32,
  parameter int NCH = 2
) (
  input  logic [DW-1:0]           up_i,
  input  logic [NCH-1:0][DW-1:0]  match_i,
  input  logic [NCH-1:0]          en_i,
  output logic [NCH-1:0]          hit_o,
  output logic [NCH-1:0]          evt_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign hit_o[g] = (up_i == match_i[g]);
    assign evt_o[g] = hit_o[g] && en_i[g];
  end
endmodule

// File: rtl/sac_status.sv
module sac_status
  import sac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic [NCH-1:0]    match_evt_i,
  input  logic              clr_we_i,
  input  logic [ST_W-1:0]   clr_bits_i,
  input  logic [NCH-1:0]    irq_en_i,
  input  logic [NCH-1:0]    pin_en_i,
  input  logic              force_i,
  output logic [ST_W-1:0]   stat_o,
  output logic              irq_o,
  output logic              wake_o,
  output logic              wake_rise_o
);
  logic            wake_q;
  logic [ST_W-1:0] set_v;
  logic [ST_W-1:0] clr_v;
  logic [ST_W-1:0] irq_mask;

  assign wake_o      = force_i || (|(stat_o[NCH-1:0] & pin_en_i));
  assign wake_rise_o = wake_o && !wake_q;

  assign set_v    = {wake_rise_o, match_evt_i};
  assign clr_v    = clr_we_i ? clr_bits_i : '0;
  assign irq_mask = {(|pin_en_i), irq_en_i};
  assign irq_o    = |(stat_o & irq_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_o <= '0;
      wake_q <= 1'b0;
    end else begin
      stat_o <= stat_next(stat_o, set_v, clr_v, clear_i);
      wake_q <= wake_o;
    end
  end
endmodule

// File: rtl/sac_regbank.sv
module sac_regbank
  import sac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sel_i,
  input  logic                   wr_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic [DW-1:0]          up_i,
  input  logic [DW-1:0]          dn_i,
  input  logic [ST_W-1:0]        stat_i,
  output logic [CTRL_W-1:0]      ctrl_o,
  output logic [NCH-1:0][DW-1:0] match_o,
  output logic [DW-1:0]          key_o,
  output logic                   ld_up_o,
  output logic                   ld_dn_o,
  output logic                   stat_we_o,
  output logic                   key_we_o,
  output logic [DW-1:0]          rdata_o
);
  logic          wr_go;
  logic          rd_go;
  logic [DW-1:0] rd_mux;
  logic          ma_we;
  logic          mb_we;
  logic          ctrl_we;

  assign wr_go     = sel_i && wr_i;
  assign rd_go     = sel_i && !wr_i;
  assign ld_up_o   = wr_go && (int'(idx_i) == W_UP);
  assign ld_dn_o   = wr_go && (int'(idx_i) == W_DN);
  assign ma_we     = wr_go && (int'(idx_i) == W_MA);
  assign mb_we     = wr_go && (int'(idx_i) == W_MB);
  assign ctrl_we   = wr_go && (int'(idx_i) == W_CTRL);
  assign stat_we_o = wr_go && (int'(idx_i) == W_STAT);
  assign key_we_o  = wr_go && (int'(idx_i) == W_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o  <= '0;
      match_o <= '1;
      key_o   <= '0;
    end else begin
      if (ctrl_we)  ctrl_o     <= wdata_i[CTRL_W-1:0] & CTRL_KEEP;
      if (ma_we)    match_o[0] <= wdata_i;
      if (mb_we)    match_o[1] <= wdata_i;
      if (key_we_o) key_o      <= wdata_i;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (int'(idx_i))
      W_UP:   rd_mux = up_i;
      W_DN:   rd_mux = dn_i;
      W_MA:   rd_mux = match_o[0];
      W_MB:   rd_mux = match_o[1];
      W_CTRL: rd_mux = {{(DW-CTRL_W){1'b0}}, ctrl_o};
      W_STAT: rd_mux = {{(DW-ST_W){1'b0}}, stat_i};
      W_KEY:  rd_mux = key_o;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_o <= '0;
    else if (rd_go) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/sec_alarm_core.sv
module sec_alarm_core
  import sac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick_i,
  input  logic             bus_sel_i,
  input  logic             bus_wr_i,
  input  logic [IDX_W-1:0] bus_idx_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  output logic             irq_o,
  output logic             wake_o
);
  logic [CTRL_W-1:0]      ctrl_q;
  logic [NCH-1:0][DW-1:0] match_q;
  logic [DW-1:0]          key_q;
  logic [DW-1:0]          cnt_up;
  logic [DW-1:0]          cnt_dn;
  logic [ST_W-1:0]        stat_q;
  logic                   ld_up;
  logic                   ld_dn;
  logic                   stat_we;
  logic                   key_we;
  logic                   cnt_step;
  logic [NCH-1:0]         match_hit;
  logic [NCH-1:0]         match_evt;
  logic                   wake_rise;
  logic                   soft_rst;
  logic                   frz;
  logic                   force_pin;
  logic [NCH-1:0]         men;
  logic [NCH-1:0]         pen;

  assign soft_rst  = ctrl_q[C_SRST];
  assign frz       = ctrl_q[C_FRZ];
  assign force_pin = ctrl_q[C_FORCE];
  assign men       = {ctrl_q[C_MEN1], ctrl_q[C_MEN0]};
  assign pen       = {ctrl_q[C_PEN1], ctrl_q[C_PEN0]};

  sac_regbank #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .sel_i(bus_sel_i), .wr_i(bus_wr_i), .idx_i(bus_idx_i), .wdata_i(bus_wdata_i),
    .up_i(cnt_up), .dn_i(cnt_dn), .stat_i(stat_q),
    .ctrl_o(ctrl_q), .match_o(match_q), .key_o(key_q),
    .ld_up_o(ld_up), .ld_dn_o(ld_dn), .stat_we_o(stat_we), .key_we_o(key_we),
    .rdata_o(bus_rdata_o)
  );

  sac_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(sec_tick_i), .hold_i(frz), .clear_i(soft_rst),
    .ld_up_i(ld_up), .ld_dn_i(ld_dn), .ld_val_i(bus_wdata_i),
    .up_o(cnt_up), .dn_o(cnt_dn), .step_o(cnt_step)
  );

  sac_compare #(.DW(DW), .NCH(NCH)) u_cmp (
    .up_i(cnt_up), .match_i(match_q), .en_i(men),
    .hit_o(match_hit), .evt_o(match_evt)
  );

  sac_status u_stat (
    .clk(clk), .rst_n(rst_n), .clear_i(soft_rst),
    .match_evt_i(match_evt), .clr_we_i(stat_we), .clr_bits_i(bus_wdata_i[ST_W-1:0]),
    .irq_en_i(men), .pin_en_i(pen), .force_i(force_pin),
    .stat_o(stat_q), .irq_o(irq_o), .wake_o(wake_o), .wake_rise_o(wake_rise)
  );
endmodule

// File: rtl/sac_checker.sv
module sac_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          frz,
  input logic          soft_rst,
  input logic          ld_up,
  input logic          ld_dn,
  input logic [DW-1:0] cnt_up,
  input logic [DW-1:0] cnt_dn,
  input logic [2:0]    stat,
  input logic [1:0]    match_evt,
  input logic          irq,
  input logic          wake,
  input logic          force_pin,
  input logic          key_we,
  input logic [DW-1:0] key
);
  // R2: an unobstructed tick adds one
  assert_tick_adds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !frz && !soft_rst && !ld_up) |=> (cnt_up == $past(cnt_up) + 1'b1));

  // R3: frozen counter holds
  assert_freeze_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && !soft_rst && !ld_up) |=> $stable(cnt_up));

  // R4: inverse relation survives unless software loads
  assert_complement_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_dn == ~cnt_up) && !ld_up && !ld_dn) |=> (cnt_dn == ~cnt_up));

  // R5: armed match latches its flag
  assert_match_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt[0] && !soft_rst) |=> stat[0]);

  // R7: no flag, no interrupt
  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == 3'b000) |-> !irq);

  // R8: force drives the pin
  assert_force_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    force_pin |-> wake);

  // R9: pin rising edge recorded
  assert_wake_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wake) && !soft_rst) |=> stat[2]);

  // R10: soft reset wipes counters and flags
  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cnt_up == '0 && cnt_dn == '1 && stat == 3'b000));

  // R11: key only changes on its own write
  assert_key_retained_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !key_we |=> $stable(key));
endmodule

bind sec_alarm_core sac_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(sec_tick_i), .frz(frz), .soft_rst(soft_rst),
  .ld_up(ld_up), .ld_dn(ld_dn), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
  .stat(stat_q), .match_evt(match_evt), .irq(irq_o), .wake(wake_o),
  .force_pin(force_pin), .key_we(key_we), .key(key_q)
);

// File: tb/tb_sec_alarm_core.sv
`timescale 1ns/1ps
module tb_sec_alarm_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [5:0]  idx = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        wake;

  typedef struct { logic [31:0] exp; string req; } exp_t;
  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  logic rd_pend = 1'b0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  sec_alarm_core dut (
    .clk(clk), .rst_n(rst_n), .sec_tick_i(tick), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_idx_i(idx), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  always @(posedge clk) rd_pend <= sel && !wr;

  // monitor: compare each returned word against the queued expectation
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL %s: read data %h with nothing expected", "R2", rdata);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        n_cmp++;
        if (rdata !== e.exp) begin
          n_bad++;
          $display("FAIL %s: read got %h expected %h", e.req, rdata, e.exp);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; idx = 6'(a); wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input int a, input logic [31:0] e, input string req);
    exp_t it;
    it.exp = e; it.req = req;
    exp_q.push_back(it);
    sel = 1'b1; wr = 1'b0; idx = 6'(a);
    @(negedge clk);
    sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(input int n);
    repeat (n) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic pin_chk(input logic act, input logic e, input string what, input string req);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: %s got %b expected %b", req, what, act, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    pin_chk(irq, 1'b0, "irq after reset", "R1");
    pin_chk(wake, 1'b0, "wake after reset", "R1");
    bus_read(0, 32'h0, "R1");
    bus_read(1, 32'hFFFF_FFFF, "R1");
    bus_read(2, 32'hFFFF_FFFF, "R1");
    bus_read(3, 32'hFFFF_FFFF, "R1");
    bus_read(4, 32'h0, "R1");
    bus_read(5, 32'h0, "R1");
    bus_read(6, 32'h0, "R1");

    // R2 ticks move both counters
    pulse(3);
    bus_read(0, 32'd3, "R2");
    bus_read(1, 32'hFFFF_FFFC, "R2");

    // R3 freeze
    bus_write(4, 32'h40);
    pulse(2);
    bus_read(0, 32'd3, "R3");
    bus_read(1, 32'hFFFF_FFFC, "R3");

    // R4 loads while frozen, complement kept across a tick
    bus_write(0, 32'd100);
    bus_write(1, 32'hFFFF_FFFF - 32'd100);
    bus_write(4, 32'h0);
    pulse(1);
    bus_read(0, 32'd101, "R4");
    bus_read(1, 32'hFFFF_FFFF - 32'd101, "R4");

    // R5 match A latches one edge after equality
    bus_write(2, 32'd103);
    bus_write(4, 32'h01);
    pulse(2);
    pin_chk(irq, 1'b0, "irq before flag edge", "R5");
    idle(1);
    pin_chk(irq, 1'b1, "irq on match A", "R7");
    pin_chk(wake, 1'b0, "wake without pin enable", "R8");
    bus_read(5, 32'h1, "R5");
    // R6 write of zero keeps the flag
    bus_write(5, 32'h0);
    bus_read(5, 32'h1, "R6");
    // R7 enable off masks the request but keeps the flag
    bus_write(4, 32'h0);
    pin_chk(irq, 1'b0, "irq with enable off", "R7");
    bus_read(5, 32'h1, "R7");
    bus_write(4, 32'h01);
    pin_chk(irq, 1'b1, "irq with enable back", "R7");
    // R5 all-ones parks the alarm, R6 write-one clears
    bus_write(2, 32'hFFFF_FFFF);
    bus_write(5, 32'h1);
    bus_read(5, 32'h0, "R6");
    pin_chk(irq, 1'b0, "irq after clear", "R6");

    // R8 / R9 match B routed to the pin
    bus_write(3, 32'd105);
    bus_write(4, 32'h0A);
    pulse(2);
    idle(1);
    pin_chk(wake, 1'b1, "wake on match B", "R8");
    pin_chk(irq, 1'b1, "irq on match B", "R7");
    idle(1);
    bus_read(5, 32'h6, "R9");
    bus_write(3, 32'hFFFF_FFFF);
    bus_write(5, 32'h2);
    pin_chk(wake, 1'b0, "wake after B cleared", "R8");
    bus_read(5, 32'h4, "R9");
    pin_chk(irq, 1'b1, "irq from pin flag", "R7");
    bus_write(5, 32'h4);
    pin_chk(irq, 1'b0, "irq after pin flag clear", "R7");
    bus_write(4, 32'h0);

    // R8 force
    bus_write(4, 32'h80);
    pin_chk(wake, 1'b1, "wake forced", "R8");
    idle(1);
    bus_read(5, 32'h4, "R9");
    pin_chk(irq, 1'b0, "irq pin flag unrouted", "R7");
    bus_write(4, 32'h0);
    bus_write(5, 32'h4);
    pin_chk(wake, 1'b0, "wake released", "R8");

    // R10 soft reset, R11 key retention
    bus_write(6, 32'hB5C1_3F27);
    bus_write(2, 32'h55);
    bus_write(4, 32'h10);
    pulse(1);
    bus_read(0, 32'h0, "R10");
    bus_read(1, 32'hFFFF_FFFF, "R10");
    bus_read(6, 32'hB5C1_3F27, "R11");
    bus_read(2, 32'h55, "R10");
    bus_read(4, 32'h10, "R10");
    bus_write(4, 32'h0);
    pulse(1);
    bus_read(0, 32'd1, "R10");
    bus_read(1, 32'hFFFF_FFFE, "R10");

    // R11 masked control bit and unmapped words
    bus_write(4, 32'hFF);
    bus_read(4, 32'hDF, "R11");
    pin_chk(wake, 1'b1, "wake with all control bits", "R8");
    bus_write(4, 32'h0);
    bus_write(5, 32'h7);
    bus_read(7, 32'h0, "R11");
    bus_read(63, 32'h0, "R11");
    bus_read(6, 32'hB5C1_3F27, "R11");

    idle(2);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R2: %0d reads got no data expected 0 pending", exp_q.size());
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule